// File: doc/BRIEF.md
# Message Signaled Interrupt Capability Registers

This block holds the register set that a PCI function shows software for message signaled interrupts. Configuration accesses reach it through a byte-offset port that takes 2-byte or 4-byte little-endian writes. Reads return the aligned 32-bit word that contains the offset. The registers are the control word, the lower address, an optional upper address, the message data, and optional mask and pending words. Two elaboration flags select 64-bit addressing and per-vector masking. These flags move the offsets of the registers that follow them, and they also set the capability length.

On the interrupt side there is one request input for each vector. A request on a vector that is enabled and not masked becomes a single memory-write message, made of an address and a data word. The vector index is placed in the low data bits that software opened up through the multiple-message-enable field. A request on a masked vector waits in the vector's pending bit. It is sent once the vector is unmasked.

Top module: `msi_cap_block`

## Requirements
- R1: After reset the control word (read as the upper half of the word at offset 0x0) holds enable=0 in bit 0, the capable-vector code (parameter MMC) in bits 3:1, zero in bits 6:4, the 64-bit flag in bit 7, the mask flag in bit 8 and zero in bits 15:9. Message outputs are idle.
- R2: Only control bit 0 and bits 6:4 are writable. The write goes through a 2-byte write at offset 0x2 (low half of the write data) or a 4-byte write at 0x0 (upper half). All other control bits keep their reset values.
- R3: A 4-byte write at 0x4 stores the lower address with bits 1:0 forced to zero.
- R4: With 64-bit addressing the upper address is at 0x8, the data at 0xC, the mask at 0x10 and the pending word at 0x14. Without it the data is at 0x8, the mask at 0xC and the pending word at 0x10.
- R5: The message data takes a 2-byte or a 4-byte write at its offset and keeps only the low 16 bits. It reads back zero-extended.
- R6: A write of a length other than 2 or 4 bytes, or to an offset that is not writable in the current layout, changes nothing. Such a write raises `cfg_err` for exactly one cycle. The pending word is read-only.
- R7: Without per-vector masking the mask offset is invalid and no vector is ever treated as masked.
- R8: `cap_len` equals 0x0A, plus 0x04 with 64-bit addressing, plus 0x0A with per-vector masking.
- R9: With enable set and a field value k ≤ 5 in bits 6:4, vectors 0 to 2^k−1 are enabled. A value above 5 enables none. Requests on vectors that are not enabled, or requests made while enable is clear, are dropped.
- R10: A request accepted at one clock edge produces `msg_valid` one edge later. The address is {upper, lower} with 64-bit addressing and {32'b0, lower} without it. The data is the 16-bit message data, zero-extended, with its low k bits replaced by the vector index.
- R11: A request on a masked vector sets its pending bit and sends nothing. When the mask bit is cleared while enable is set, the message is sent and the pending bit clears.
- R12: When several vectors are ready in the same cycle, one message goes out per cycle, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_off | input | 8 | Byte offset within the capability |
| cfg_bytes | input | 3 | Access length in bytes |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_rdata | output | 32 | Registered aligned read word |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |
| irq_req | input | 2**MMC | Per-vector request pulses |
| msg_valid | output | 1 | Message strobe |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| cap_len | output | 8 | Capability length in bytes |

## Verification
The bench builds two instances. The first uses the defaults: 64-bit addressing, per-vector masking and 32 vectors. It covers the long layout, mask and pending behaviour, index substitution for several field values, and the disabled and out-of-range field cases. The second uses 32-bit addressing, no masking and 8 vectors. It covers the short layout, the invalid mask offset, zero-extended addresses and a reset value for a different capable-vector code.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam logic [15:0] CTL_WR_MASK = 16'h0071;
  localparam int CTL_EN_BIT = 0;

  // bitmask of enabled vectors for a multiple-message-enable code
  function automatic logic [31:0] vec_en_mask(input logic [2:0] mme);
    logic [63:0] t;
    logic [6:0]  n;
    if (mme > 3'd5) return 32'h0;
    n = 7'd1 << mme;
    t = (64'd1 << n) - 64'd1;
    return t[31:0];
  endfunction

  function automatic logic [15:0] low_bits_mask(input logic [2:0] mme);
    logic [31:0] t;
    t = (32'd1 << mme) - 32'd1;
    return t[15:0];
  endfunction
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int ADDR64 = 1,
  parameter int PVM    = 1,
  parameter int MMC    = 5,
  parameter int NVEC   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rd,
  input  logic [7:0]      cfg_off,
  input  logic [2:0]      cfg_bytes,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            cfg_err,
  input  logic [NVEC-1:0] pend,
  output logic [15:0]     ctl,
  output logic [63:0]     addr,
  output logic [15:0]     data16,
  output logic [NVEC-1:0] mask_eff
);
  localparam logic [7:0]  DATA_OFF = (ADDR64 != 0) ? 8'h0C : 8'h08;
  localparam logic [7:0]  MASK_OFF = DATA_OFF + 8'h04;
  localparam logic [7:0]  PEND_OFF = MASK_OFF + 8'h04;
  localparam logic [15:0] CTL_RST  = {7'b0, (PVM != 0), (ADDR64 != 0), 3'b000, 3'(MMC), 1'b0};

  logic [15:0] ctl_q;
  logic [31:0] lo_q, hi_q, mask_q;
  logic [15:0] data_q;
  logic        b2, b4;
  logic        hit_ctl, hit_lo, hit_hi, hit_data, hit_mask, any_hit;
  logic [15:0] ctl_w;
  logic [31:0] rd_word;
  logic [7:0]  rd_base;

  assign b2 = (cfg_bytes == 3'd2);
  assign b4 = (cfg_bytes == 3'd4);

  always_comb begin
    hit_ctl  = (b2 && cfg_off == 8'h02) || (b4 && cfg_off == 8'h00);
    hit_lo   = b4 && cfg_off == 8'h04;
    hit_hi   = (ADDR64 != 0) && b4 && cfg_off == 8'h08;
    hit_data = (b2 || b4) && cfg_off == DATA_OFF;
    hit_mask = (PVM != 0) && b4 && cfg_off == MASK_OFF;
    any_hit  = hit_ctl | hit_lo | hit_hi | hit_data | hit_mask;
    ctl_w    = b4 ? cfg_wdata[31:16] : cfg_wdata[15:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_RST;
      lo_q    <= '0;
      hi_q    <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_wr && !any_hit;
      if (cfg_wr) begin
        if (hit_ctl)  ctl_q  <= (ctl_q & ~CTL_WR_MASK) | (ctl_w & CTL_WR_MASK);
        if (hit_lo)   lo_q   <= {cfg_wdata[31:2], 2'b00};
        if (hit_hi)   hi_q   <= cfg_wdata;
        if (hit_data) data_q <= cfg_wdata[15:0];
        if (hit_mask) mask_q <= cfg_wdata;
      end
    end
  end

  // read path: whole aligned word
  always_comb begin
    rd_base = {cfg_off[7:2], 2'b00};
    rd_word = 32'h0;
    if (rd_base == 8'h00)                       rd_word = {ctl_q, 16'h0};
    else if (rd_base == 8'h04)                  rd_word = lo_q;
    else if (ADDR64 != 0 && rd_base == 8'h08)   rd_word = hi_q;
    else if (rd_base == DATA_OFF)               rd_word = {16'h0, data_q};
    else if (PVM != 0 && rd_base == MASK_OFF)   rd_word = mask_q;
    else if (PVM != 0 && rd_base == PEND_OFF)   rd_word = 32'(pend);
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_word;
  end

  assign ctl    = ctl_q;
  assign data16 = data_q;
  assign addr   = (ADDR64 != 0) ? {hi_q, lo_q} : {32'h0, lo_q};

  generate
    if (PVM != 0) begin : g_mask
      assign mask_eff = mask_q[NVEC-1:0];
    end else begin : g_nomask
      assign mask_eff = '0;
    end
  endgenerate

  // R2: read-only control bits never move
  p_ro_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ctl_q & ~CTL_WR_MASK));
  // R6: error pulse only follows a write
  p_err_after_wr_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_wr));
endmodule

// File: rtl/msi_vec_arb.sv
module msi_vec_arb
  import msi_cap_pkg::*;
#(
  parameter int MMC  = 5,
  parameter int NVEC = 32,
  parameter int VW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msi_en,
  input  logic [2:0]      mme,
  input  logic [NVEC-1:0] mask_eff,
  input  logic [NVEC-1:0] irq_req,
  input  logic [63:0]     addr,
  input  logic [15:0]     data16,
  output logic [NVEC-1:0] pend,
  output logic            msg_valid,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  logic [31:0]     en_all;
  logic [NVEC-1:0] en_vec, elig, clr, pend_q;
  logic            pick_any;
  logic [VW-1:0]   pick_idx;
  logic [15:0]     lowm;

  assign en_all = vec_en_mask(mme);
  assign en_vec = en_all[NVEC-1:0] & {NVEC{msi_en}};
  assign elig   = pend_q & ~mask_eff & en_vec;
  assign lowm   = low_bits_mask(mme);

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    clr      = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_any = 1'b1;
        pick_idx = i[VW-1:0];
      end
    end
    if (pick_any) clr[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q    <= (pend_q & ~clr) | (irq_req & en_vec);
      msg_valid <= pick_any;
      if (pick_any) begin
        msg_addr <= addr;
        msg_data <= {16'h0, (data16 & ~lowm) | (16'(pick_idx) & lowm)};
      end
    end
  end

  assign pend = pend_q;

  // R9: a message only follows a cycle with MSI enabled
  p_msg_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(msi_en));
  // R11: a masked outstanding bit is never dropped
  p_masked_hold_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q & mask_eff) & ~pend_q) == '0));
  // R12: at most one vector retired per cycle
  p_one_retire_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));
endmodule

// File: rtl/msi_cap_block.sv
module msi_cap_block
  import msi_cap_pkg::*;
#(
  parameter int ADDR64 = 1,
  parameter int PVM    = 1,
  parameter int MMC    = 5,
  localparam int NVEC  = 1 << MMC,
  localparam int VW    = (MMC == 0) ? 1 : MMC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rd,
  input  logic [7:0]      cfg_off,
  input  logic [2:0]      cfg_bytes,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            cfg_err,
  input  logic [NVEC-1:0] irq_req,
  output logic            msg_valid,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic [7:0]      cap_len
);
  localparam logic [7:0] CAP_LEN = 8'h0A + ((ADDR64 != 0) ? 8'h04 : 8'h00)
                                         + ((PVM != 0) ? 8'h0A : 8'h00);

  logic [15:0]     ctl;
  logic [63:0]     addr;
  logic [15:0]     data16;
  logic [NVEC-1:0] mask_eff, pend;

  msi_cap_regs #(.ADDR64(ADDR64), .PVM(PVM), .MMC(MMC), .NVEC(NVEC)) regs_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_off(cfg_off),
    .cfg_bytes(cfg_bytes), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .pend(pend), .ctl(ctl), .addr(addr), .data16(data16),
    .mask_eff(mask_eff)
  );

  msi_vec_arb #(.MMC(MMC), .NVEC(NVEC), .VW(VW)) arb_i (
    .clk(clk), .rst(rst), .msi_en(ctl[CTL_EN_BIT]), .mme(ctl[6:4]),
    .mask_eff(mask_eff), .irq_req(irq_req), .addr(addr), .data16(data16),
    .pend(pend), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  assign cap_len = CAP_LEN;
endmodule

// File: tb/msi_cap_block_tb_top.sv
module msi_cap_block_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [7:0]  off;
  logic [2:0]  bytes;
  logic [31:0] wdata;
  logic        wr_a, rd_a, wr_b, rd_b;
  logic [31:0] rdata_a, rdata_b, irq_a;
  logic [7:0]  irq_b;
  logic        err_a, err_b, mv_a, mv_b;
  logic [63:0] ma_a, ma_b;
  logic [31:0] md_a, md_b;
  logic [7:0]  len_a, len_b;

  msi_cap_block dut_i (
    .clk(clk), .rst(rst), .cfg_wr(wr_a), .cfg_rd(rd_a), .cfg_off(off),
    .cfg_bytes(bytes), .cfg_wdata(wdata), .cfg_rdata(rdata_a), .cfg_err(err_a),
    .irq_req(irq_a), .msg_valid(mv_a), .msg_addr(ma_a), .msg_data(md_a), .cap_len(len_a)
  );

  msi_cap_block #(.ADDR64(0), .PVM(0), .MMC(3)) dut_b (
    .clk(clk), .rst(rst), .cfg_wr(wr_b), .cfg_rd(rd_b), .cfg_off(off),
    .cfg_bytes(bytes), .cfg_wdata(wdata), .cfg_rdata(rdata_b), .cfg_err(err_b),
    .irq_req(irq_b), .msg_valid(mv_b), .msg_addr(ma_b), .msg_data(md_b), .cap_len(len_b)
  );

  int checks = 0;
  int fails  = 0;
  int cnt_a = 0, cnt_b = 0;
  logic [31:0] log_a [8];
  logic [63:0] last_addr_a, last_addr_b;
  logic [31:0] last_data_a, last_data_b;

  always @(negedge clk) begin
    if (mv_a) begin
      if (cnt_a < 8) log_a[cnt_a] = md_a;
      last_addr_a = ma_a; last_data_a = md_a; cnt_a++;
    end
    if (mv_b) begin
      last_addr_b = ma_b; last_data_b = md_b; cnt_b++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cwr(input bit s, input logic [2:0] b, input logic [7:0] o,
                     input logic [31:0] d, output logic e);
    @(negedge clk);
    off = o; bytes = b; wdata = d;
    if (s) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
    e = s ? err_b : err_a;
  endtask

  task automatic crd(input bit s, input logic [7:0] o, output logic [31:0] d);
    @(negedge clk);
    off = o; bytes = 3'd4;
    if (s) rd_b = 1'b1; else rd_a = 1'b1;
    @(negedge clk);
    rd_a = 1'b0; rd_b = 1'b0;
    d = s ? rdata_b : rdata_a;
  endtask

  task automatic pulse(input bit s, input logic [31:0] v);
    @(negedge clk);
    if (s) irq_b = v[7:0]; else irq_a = v;
    @(negedge clk);
    irq_a = '0; irq_b = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // {bytes, offset, wdata, read offset, expected read, expected err}
  localparam int NT = 12;
  localparam logic [83:0] TBL [NT] = '{
    {3'd4, 8'h00, 32'hFFFF_FFFF, 8'h00, 32'h01FB_0000, 1'b0},  // R2
    {3'd2, 8'h02, 32'h0000_0000, 8'h00, 32'h018A_0000, 1'b0},  // R2
    {3'd4, 8'h04, 32'h1234_567F, 8'h04, 32'h1234_567C, 1'b0},  // R3
    {3'd4, 8'h08, 32'hDEAD_BEEF, 8'h08, 32'hDEAD_BEEF, 1'b0},  // R4
    {3'd2, 8'h0C, 32'h0000_ABCD, 8'h0C, 32'h0000_ABCD, 1'b0},  // R5
    {3'd4, 8'h0C, 32'h5555_1240, 8'h0C, 32'h0000_1240, 1'b0},  // R5
    {3'd4, 8'h10, 32'h0000_00F0, 8'h10, 32'h0000_00F0, 1'b0},  // R4
    {3'd3, 8'h04, 32'hFFFF_FFFF, 8'h04, 32'h1234_567C, 1'b1},  // R6
    {3'd2, 8'h04, 32'hFFFF_FFFF, 8'h04, 32'h1234_567C, 1'b1},  // R6
    {3'd4, 8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000, 1'b1},  // R6
    {3'd4, 8'h18, 32'hFFFF_FFFF, 8'h0C, 32'h0000_1240, 1'b1},  // R6
    {3'd1, 8'h0C, 32'h0000_00FF, 8'h0C, 32'h0000_1240, 1'b1}   // R6
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic        e;
    logic [31:0] r;
    int          n0;
    rst = 1'b1; off = '0; bytes = '0; wdata = '0;
    wr_a = 0; rd_a = 0; wr_b = 0; rd_b = 0; irq_a = '0; irq_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    crd(0, 8'h00, r); chk("R1 reset ctl A", r, 32'h018A_0000);
    crd(1, 8'h00, r); chk("R1 reset ctl B", r, 32'h0006_0000);
    chk("R8 cap_len A", len_a, 8'h18);
    chk("R8 cap_len B", len_b, 8'h0A);
    chk("R10 idle msg A", mv_a, 1'b0);

    for (int i = 0; i < NT; i++) begin
      logic [83:0] t;
      t = TBL[i];
      cwr(0, t[83:81], t[80:73], t[72:41], e);
      chk($sformatf("R6 table err row %0d", i), e, t[0]);
      crd(0, t[40:33], r);
      chk($sformatf("table read row %0d", i), r, t[32:1]);
    end

    // R6 pulse width
    cwr(0, 3'd4, 8'h20, 32'h1, e);
    @(negedge clk);
    chk("R6 err one cycle", err_a, 1'b0);

    // enable four vectors
    cwr(0, 3'd4, 8'h10, 32'h0, e);
    cwr(0, 3'd2, 8'h0C, 32'h0000_ABC3, e);
    cwr(0, 3'd2, 8'h02, 32'h0000_0021, e);
    crd(0, 8'h00, r); chk("R2 enable ctl", r, 32'h01AB_0000);

    n0 = cnt_a;
    pulse(0, 32'h4); idle(4);
    chk("R10 one message", cnt_a - n0, 1);
    chk("R10 addr 64", last_addr_a, 64'hDEAD_BEEF_1234_567C);
    chk("R10 data idx", last_data_a, 32'h0000_ABC2);

    n0 = cnt_a;
    pulse(0, 32'h20); idle(4);
    chk("R9 vector above count dropped", cnt_a - n0, 0);

    cwr(0, 3'd4, 8'h10, 32'h2, e);
    n0 = cnt_a;
    pulse(0, 32'h2); idle(4);
    chk("R11 masked no message", cnt_a - n0, 0);
    crd(0, 8'h14, r); chk("R11 pending set", r, 32'h2);
    cwr(0, 3'd4, 8'h10, 32'h0, e); idle(3);
    chk("R11 unmask sends", cnt_a - n0, 1);
    chk("R11 unmask data", last_data_a, 32'h0000_ABC1);
    crd(0, 8'h14, r); chk("R11 pending cleared", r, 32'h0);

    n0 = cnt_a;
    pulse(0, 32'h9); idle(5);
    chk("R12 two messages", cnt_a - n0, 2);
    chk("R12 first lowest", log_a[n0], 32'h0000_ABC0);
    chk("R12 second", log_a[n0+1], 32'h0000_ABC3);

    cwr(0, 3'd2, 8'h02, 32'h0000_0020, e);
    n0 = cnt_a;
    pulse(0, 32'h1); idle(4);
    chk("R9 disabled drops", cnt_a - n0, 0);

    cwr(0, 3'd2, 8'h02, 32'h0000_0061, e);
    crd(0, 8'h00, r); chk("R9 ctl code 6", r, 32'h01EB_0000);
    n0 = cnt_a;
    pulse(0, 32'h1); idle(4);
    chk("R9 code above 5 no vectors", cnt_a - n0, 0);

    cwr(0, 3'd2, 8'h02, 32'h0000_0001, e);
    n0 = cnt_a;
    pulse(0, 32'h1); idle(4);
    chk("R10 single vector count", cnt_a - n0, 1);
    chk("R10 single vector data kept", last_data_a, 32'h0000_ABC3);

    // instance with 32-bit address, no masking
    cwr(1, 3'd4, 8'h08, 32'h0000_0077, e);
    chk("R4 short layout data err", e, 1'b0);
    crd(1, 8'h08, r); chk("R4 short layout data", r, 32'h0000_0077);
    cwr(1, 3'd4, 8'h0C, 32'hFFFF_FFFF, e);
    chk("R7 no mask offset", e, 1'b1);
    cwr(1, 3'd4, 8'h04, 32'h0000_1003, e);
    cwr(1, 3'd2, 8'h02, 32'h0000_0011, e);
    n0 = cnt_b;
    pulse(1, 32'h1); idle(4);
    chk("R7 never masked", cnt_b - n0, 1);
    chk("R10 addr 32", last_addr_b, 64'h0000_0000_0000_1000);
    chk("R10 data B", last_data_b, 32'h0000_0076);

    finish_run();
  end
endmodule